// File: doc/BRIEF.md
# LCD Row-Scan Timing and Drive-Level Encoder

This block paces the row scan of a multiplexed dot-matrix liquid crystal panel and gives each row (common) and column (segment) electrode a 2-bit code that names the analog level to drive. Each rising edge of the display clock moves the scan to the next common line. After the last line the scan returns to line 0 and the polarity-alternation signal flips, so the panel never sees a DC bias. A frame-sync pulse marks line 0. Each segment code depends on that column's data bit for the current row, the polarity signal and a display-invert flag. Each common code depends on whether that row is being scanned and on the polarity.

A master/slave strap lets two chips drive one wide panel. The master makes the polarity and frame-sync signals and drives them out. It may also drive the display clock out when its local oscillator is the source. A slave takes the display clock, polarity and sync from the master. It stays blank until it sees a sync pulse on a clock edge, and it realigns its line counter on every later sync. A power-save input forces every electrode code to the top-rail level.

The sequencer has four states. `ST_SAVE` holds the counter at line 0 with polarity 0 and blanks every output. `ST_MASTER` scans from the local timing. `ST_SLV_WAIT` stays blank until the first sync. `ST_SLAVE` scans from the master's timing. The transitions are as follows:
- SAVE→MASTER: power-save is low and the strap selects master.
- SAVE→SLV_WAIT: power-save is low and the strap selects slave.
- SLV_WAIT→SLAVE: a display-clock edge arrives while sync_in is high.
- Any running state→SAVE: power-save goes high or the strap changes.

Top module: `lcd_scan_drive`

## Requirements
- R1: While rst_n is low and in the cycle after it, all level codes are 00, and fr_out and sync_out are 0.
- R2: Codes are 00 = top rail (VDD), 01 = V1 on commons or V2 on segments, 10 = V4 on commons or V3 on segments, 11 = V5. With reverse=0, a segment whose data bit is 1 gets 00 when polarity is 1 and 11 when polarity is 0. A segment whose data bit is 0 gets 01 when polarity is 1 and 10 when polarity is 0.
- R3: With reverse=1, a segment whose data bit is 1 gets 01 when polarity is 1 and 10 when polarity is 0. A segment whose data bit is 0 gets 00 when polarity is 1 and 11 when polarity is 0.
- R4: While scanning, exactly one common is selected: common k when the line counter is k. The selected common gets 11 when polarity is 1 and 00 when polarity is 0. Every other common gets 01 when polarity is 1 and 10 when polarity is 0. Common bits [2k+1:2k] belong to common k, and segment bits [2j+1:2j] belong to segment j.
- R5: The line counter advances by exactly one for each rising edge of the selected display clock. It advances in the cycle after the edge is sampled. A clock held high does not advance it again.
- R6: After line NUM_COM-1 the counter returns to 0, and in master mode the polarity (fr_out) toggles at that wrap.
- R7: In master mode, sync_out is 1 exactly while the line counter is 0.
- R8: The display clock source is selected as follows:
  - Master with use_int_osc=1: osc_tick is the source and cl_in is ignored.
  - Master with use_int_osc=0: cl_in is the source and osc_tick is ignored.
  - Slave: cl_in is the source.
  - cl_oe is 1 only for master with use_int_osc=1.
- R9: power_save=1 makes every code 00 from the next cycle. When power_save is released, the scan restarts at line 0 with polarity 0.
- R10: A slave stays blank (all codes 00) until a display-clock edge arrives with sync_in=1. Its line then becomes 1. From then on it uses fr_in directly as its polarity, and every edge that arrives with sync_in=1 sets its line to 1.
- R11: timing_oe equals is_master. In slave mode, fr_out and sync_out are 0.
- R12: A change of is_master while scanning passes through ST_SAVE, blanking the outputs for one cycle, and restarts the scan in the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | Strap: 1 = master, 0 = slave |
| use_int_osc | input | 1 | Strap: 1 = local oscillator is the display clock |
| osc_tick | input | 1 | Local oscillator display clock (level, sync to clk) |
| cl_in | input | 1 | External display clock (level, sync to clk) |
| fr_in | input | 1 | Polarity from the master (slave mode) |
| sync_in | input | 1 | Frame sync from the master (slave mode) |
| power_save | input | 1 | Force all electrodes to the top-rail level |
| reverse | input | 1 | Invert the displayed data |
| seg_data | input | NUM_SEG | Data bits of the row being scanned |
| cl_out | output | 1 | Display clock driven out (master, local oscillator) |
| cl_oe | output | 1 | Enable for cl_out |
| fr_out | output | 1 | Polarity driven out (master) |
| sync_out | output | 1 | Frame sync driven out (master) |
| timing_oe | output | 1 | Enable for fr_out and sync_out |
| seg_lvl | output | 2*NUM_SEG | Segment level codes |
| com_lvl | output | 2*NUM_COM | Common level codes |

## Verification
The bench uses a small build with 5 commons and 8 segments.

- Segments: every 8-bit data pattern is applied under both reverse settings and both polarities. A mistake in the data, the reverse flag or the polarity term therefore shows up as a wrong code on some column.
- Scan timing: the common vector is checked after each clock edge across more than two frames. This separates an off-by-one wrap, a missing polarity toggle and a misplaced sync.
- Clock source: edges are sent on the non-selected clock, and one clock is held high for several cycles. These show whether the source select and the edge detector are correct.
- Slave: the slave runs with no sync, then a first sync, then a late resync. This shows whether it blanks, locks and realigns as required.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        ST_SAVE     = 2'd0,
        ST_MASTER   = 2'd1,
        ST_SLV_WAIT = 2'd2,
        ST_SLAVE    = 2'd3
    } scan_state_e;

    localparam logic [1:0] LVL_TOP   = 2'b00;
    localparam logic [1:0] LVL_NEAR  = 2'b01;
    localparam logic [1:0] LVL_FAR   = 2'b10;
    localparam logic [1:0] LVL_BOT   = 2'b11;

    // Segment: effective pixel = data xor reverse.
    function automatic logic [1:0] seg_code(input logic dat, input logic pol, input logic inv);
        logic lit;
        lit = dat ^ inv;
        if (lit) seg_code = pol ? LVL_TOP  : LVL_BOT;
        else     seg_code = pol ? LVL_NEAR : LVL_FAR;
    endfunction

    // Common: selected row takes the outer rail opposite to polarity.
    function automatic logic [1:0] com_code(input logic sel, input logic pol);
        if (sel) com_code = pol ? LVL_BOT  : LVL_TOP;
        else     com_code = pol ? LVL_NEAR : LVL_FAR;
    endfunction

endpackage

// File: rtl/lcd_clk_edge.sv
module lcd_clk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic use_int_osc,
    input  logic osc_tick,
    input  logic cl_in,
    output logic tick,
    output logic cl_out,
    output logic cl_oe
);

    logic local_src;
    logic src;
    logic src_q;

    assign local_src = is_master && use_int_osc;
    assign src       = local_src ? osc_tick : cl_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end

    assign tick   = src && !src_q;
    assign cl_oe  = local_src;
    assign cl_out = local_src && osc_tick;

endmodule

// File: rtl/lcd_line_seq.sv
module lcd_line_seq
    import lcd_scan_pkg::*;
#(
    parameter int NUM_COM = 65,
    parameter int LINE_W  = $clog2(NUM_COM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              is_master,
    input  logic              power_save,
    input  logic              sync_in,
    input  logic              fr_in,
    output logic [LINE_W-1:0] line,
    output logic              pol,
    output logic              active,
    output logic              sync_out,
    output logic              fr_out,
    output logic              timing_oe,
    output scan_state_e       state
);

    localparam logic [LINE_W-1:0] LAST = LINE_W'(NUM_COM - 1);
    localparam logic [LINE_W-1:0] ONE  = LINE_W'(1);

    scan_state_e       state_q, state_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic              fr_q, fr_d;
    logic              stop_req;
    logic              at_last;

    assign at_last  = (line_q == LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SAVE;
            line_q  <= '0;
            fr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            fr_q    <= fr_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        stop_req = power_save;
        unique case (state_q)
            ST_SAVE: begin
                if (!power_save) state_d = is_master ? ST_MASTER : ST_SLV_WAIT;
            end
            ST_MASTER: begin
                if (stop_req || !is_master) state_d = ST_SAVE;
            end
            ST_SLV_WAIT: begin
                if (stop_req || is_master)  state_d = ST_SAVE;
                else if (tick && sync_in)   state_d = ST_SLAVE;
            end
            ST_SLAVE: begin
                if (stop_req || is_master)  state_d = ST_SAVE;
            end
        endcase
    end

    // Line counter and polarity
    always_comb begin
        line_d = line_q;
        fr_d   = fr_q;
        unique case (state_q)
            ST_SAVE: begin
                line_d = '0;
                fr_d   = 1'b0;
            end
            ST_MASTER: begin
                if (tick) begin
                    line_d = at_last ? '0 : line_q + ONE;
                    if (at_last) fr_d = !fr_q;
                end
            end
            ST_SLV_WAIT: begin
                if (tick && sync_in) line_d = ONE;
            end
            ST_SLAVE: begin
                if (tick) begin
                    if (sync_in)      line_d = ONE;
                    else if (at_last) line_d = '0;
                    else              line_d = line_q + ONE;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        active   = 1'b0;
        pol      = 1'b0;
        sync_out = 1'b0;
        fr_out   = 1'b0;
        unique case (state_q)
            ST_SAVE:     ;
            ST_MASTER: begin
                active   = 1'b1;
                pol      = fr_q;
                fr_out   = fr_q;
                sync_out = (line_q == '0);
            end
            ST_SLV_WAIT: ;
            ST_SLAVE: begin
                active = 1'b1;
                pol    = fr_in;
            end
        endcase
    end

    assign timing_oe = is_master;
    assign line      = line_q;
    assign state     = state_q;

endmodule

// File: rtl/lcd_seg_enc.sv
module lcd_seg_enc
    import lcd_scan_pkg::*;
#(
    parameter int NUM_SEG = 224
) (
    input  logic                 active,
    input  logic                 pol,
    input  logic                 reverse,
    input  logic [NUM_SEG-1:0]   seg_data,
    output logic [2*NUM_SEG-1:0] seg_lvl
);

    for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
        assign seg_lvl[2*j +: 2] = active ? seg_code(seg_data[j], pol, reverse) : LVL_TOP;
    end

endmodule

// File: rtl/lcd_com_enc.sv
module lcd_com_enc
    import lcd_scan_pkg::*;
#(
    parameter int NUM_COM = 65,
    parameter int LINE_W  = $clog2(NUM_COM)
) (
    input  logic                 active,
    input  logic                 pol,
    input  logic [LINE_W-1:0]    line,
    output logic [2*NUM_COM-1:0] com_lvl
);

    for (genvar k = 0; k < NUM_COM; k++) begin : g_com
        assign com_lvl[2*k +: 2] = active ? com_code(line == LINE_W'(k), pol) : LVL_TOP;
    end

endmodule

// File: rtl/lcd_scan_drive.sv
module lcd_scan_drive
    import lcd_scan_pkg::*;
#(
    parameter int NUM_COM = 65,
    parameter int NUM_SEG = 224,
    localparam int LINE_W = $clog2(NUM_COM)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 is_master,
    input  logic                 use_int_osc,
    input  logic                 osc_tick,
    input  logic                 cl_in,
    input  logic                 fr_in,
    input  logic                 sync_in,
    input  logic                 power_save,
    input  logic                 reverse,
    input  logic [NUM_SEG-1:0]   seg_data,
    output logic                 cl_out,
    output logic                 cl_oe,
    output logic                 fr_out,
    output logic                 sync_out,
    output logic                 timing_oe,
    output logic [2*NUM_SEG-1:0] seg_lvl,
    output logic [2*NUM_COM-1:0] com_lvl
);

    logic              tick_w;
    logic [LINE_W-1:0] line_w;
    logic              pol_w;
    logic              active_w;
    scan_state_e       state_w;

    lcd_clk_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_master   (is_master),
        .use_int_osc (use_int_osc),
        .osc_tick    (osc_tick),
        .cl_in       (cl_in),
        .tick        (tick_w),
        .cl_out      (cl_out),
        .cl_oe       (cl_oe)
    );

    lcd_line_seq #(.NUM_COM(NUM_COM), .LINE_W(LINE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .is_master  (is_master),
        .power_save (power_save),
        .sync_in    (sync_in),
        .fr_in      (fr_in),
        .line       (line_w),
        .pol        (pol_w),
        .active     (active_w),
        .sync_out   (sync_out),
        .fr_out     (fr_out),
        .timing_oe  (timing_oe),
        .state      (state_w)
    );

    lcd_seg_enc #(.NUM_SEG(NUM_SEG)) u_seg (
        .active   (active_w),
        .pol      (pol_w),
        .reverse  (reverse),
        .seg_data (seg_data),
        .seg_lvl  (seg_lvl)
    );

    lcd_com_enc #(.NUM_COM(NUM_COM), .LINE_W(LINE_W)) u_com (
        .active  (active_w),
        .pol     (pol_w),
        .line    (line_w),
        .com_lvl (com_lvl)
    );

endmodule

// File: rtl/lcd_scan_drive_chk.sv
module lcd_scan_drive_chk
    import lcd_scan_pkg::*;
#(
    parameter int NUM_COM = 65,
    parameter int NUM_SEG = 224,
    parameter int LINE_W  = $clog2(NUM_COM)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 is_master,
    input logic                 power_save,
    input logic                 tick,
    input logic [LINE_W-1:0]    line,
    input logic                 pol,
    input scan_state_e          state,
    input logic                 sync_out,
    input logic                 fr_out,
    input logic [2*NUM_SEG-1:0] seg_lvl,
    input logic [2*NUM_COM-1:0] com_lvl
);

    assert_line_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(line) < NUM_COM);

    assert_wrap_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MASTER && tick && is_master && !power_save && 32'(line) == NUM_COM - 1)
        |=> (line == '0 && pol != $past(pol)));

    assert_hold_no_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MASTER && !tick && is_master && !power_save) |=> $stable(line));

    assert_save_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        power_save |=> (seg_lvl == '0 && com_lvl == '0));

    assert_sync_row0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> (com_lvl[1:0] == {fr_out, fr_out}));

endmodule

bind lcd_scan_drive lcd_scan_drive_chk #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_master  (is_master),
    .power_save (power_save),
    .tick       (tick_w),
    .line       (line_w),
    .pol        (pol_w),
    .state      (state_w),
    .sync_out   (sync_out),
    .fr_out     (fr_out),
    .seg_lvl    (seg_lvl),
    .com_lvl    (com_lvl)
);

// File: tb/sim_lcd_scan_drive.sv
module sim_lcd_scan_drive;

    localparam int NC = 5;
    localparam int NS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic is_master = 1'b1, use_int_osc = 1'b1, osc_tick = 1'b0, cl_in = 1'b0;
    logic fr_in = 1'b0, sync_in = 1'b0, power_save = 1'b0, reverse = 1'b0;
    logic [NS-1:0]   seg_data = '1;
    logic            cl_out, cl_oe, fr_out, sync_out, timing_oe;
    logic [2*NS-1:0] seg_lvl;
    logic [2*NC-1:0] com_lvl;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int eline = 0;
    bit efr = 1'b0;

    always #2 clk = ~clk;

    lcd_scan_drive #(.NUM_COM(NC), .NUM_SEG(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .use_int_osc(use_int_osc),
        .osc_tick(osc_tick), .cl_in(cl_in), .fr_in(fr_in), .sync_in(sync_in),
        .power_save(power_save), .reverse(reverse), .seg_data(seg_data),
        .cl_out(cl_out), .cl_oe(cl_oe), .fr_out(fr_out), .sync_out(sync_out),
        .timing_oe(timing_oe), .seg_lvl(seg_lvl), .com_lvl(com_lvl)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2*NC-1:0] exp_com(input int ln, input bit fr, input bit on);
        logic [2*NC-1:0] v;
        for (int i = 0; i < NC; i++) begin
            if (!on)          v[2*i +: 2] = 2'b00;
            else if (i == ln) v[2*i +: 2] = fr ? 2'b11 : 2'b00;
            else              v[2*i +: 2] = fr ? 2'b01 : 2'b10;
        end
        return v;
    endfunction

    function automatic logic [2*NS-1:0] exp_seg(input logic [NS-1:0] d, input bit fr, input bit rv);
        logic [2*NS-1:0] v;
        for (int j = 0; j < NS; j++) begin
            case ({rv, d[j], fr})
                3'b011: v[2*j +: 2] = 2'b00;
                3'b010: v[2*j +: 2] = 2'b11;
                3'b001: v[2*j +: 2] = 2'b01;
                3'b000: v[2*j +: 2] = 2'b10;
                3'b111: v[2*j +: 2] = 2'b01;
                3'b110: v[2*j +: 2] = 2'b10;
                3'b101: v[2*j +: 2] = 2'b00;
                default: v[2*j +: 2] = 2'b11;
            endcase
        end
        return v;
    endfunction

    task automatic pulse_osc();
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk) osc_tick = 1'b0;
    endtask

    task automatic pulse_cl();
        @(negedge clk) cl_in = 1'b1;
        @(negedge clk) cl_in = 1'b0;
    endtask

    task automatic model_step();
        eline = (eline + 1) % NC;
        if (eline == 0) efr = !efr;
    endtask

    task automatic seg_sweep(input bit fr);
        for (int d = 0; d < 256; d++) begin
            for (int r = 0; r < 2; r++) begin
                @(negedge clk);
                seg_data = d[NS-1:0];
                reverse  = r[0];
                #1;
                check(r ? "R3 reversed segment" : "R2 normal segment",
                      64'(seg_lvl), 64'(exp_seg(seg_data, fr, r[0])));
            end
        end
        reverse = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset
        #9;
        check("R1 seg in reset", 64'(seg_lvl), 64'(0));
        check("R1 com in reset", 64'(com_lvl), 64'(0));
        check("R1 sync/fr in reset", {62'd0, sync_out, fr_out}, 64'd0);
        @(negedge clk) rst_n = 1'b1;
        check("R1 com after reset", 64'(com_lvl), 64'(0));
        @(negedge clk);
        // Master, local oscillator, line 0
        check("R4 com line 0", 64'(com_lvl), 64'(exp_com(0, 0, 1)));
        check("R7 sync at line 0", 64'(sync_out), 64'd1);
        check("R11 timing_oe master", 64'(timing_oe), 64'd1);
        check("R8 cl_oe master int", 64'(cl_oe), 64'd1);
        // R4 R6 R7 frame sweep
        for (int k = 0; k < 2*NC + 1; k++) begin
            pulse_osc();
            model_step();
            check("R4 R6 com scan", 64'(com_lvl), 64'(exp_com(eline, efr, 1)));
            check("R6 fr_out", 64'(fr_out), 64'(efr));
            check("R7 sync_out", 64'(sync_out), 64'(eline == 0));
        end
        seg_sweep(efr);
        while (!(eline == 0 && efr == 1'b1)) begin
            pulse_osc();
            model_step();
        end
        check("R6 fr after wrap", 64'(fr_out), 64'd1);
        seg_sweep(1'b1);
        // R5 held clock
        @(negedge clk) osc_tick = 1'b1;
        repeat (4) @(negedge clk);
        osc_tick = 1'b0;
        model_step();
        check("R5 held clock one step", 64'(com_lvl), 64'(exp_com(eline, efr, 1)));
        // R8 cl_in ignored with local oscillator
        pulse_cl();
        check("R8 cl_in ignored", 64'(com_lvl), 64'(exp_com(eline, efr, 1)));
        @(negedge clk) use_int_osc = 1'b0;
        #1 check("R8 cl_oe external", 64'(cl_oe), 64'd0);
        pulse_osc();
        check("R8 osc ignored", 64'(com_lvl), 64'(exp_com(eline, efr, 1)));
        pulse_cl();
        model_step();
        check("R8 cl_in advances", 64'(com_lvl), 64'(exp_com(eline, efr, 1)));
        // R9 power save
        @(negedge clk) power_save = 1'b1;
        @(negedge clk);
        check("R9 com blank", 64'(com_lvl), 64'(0));
        check("R9 seg blank", 64'(seg_lvl), 64'(0));
        check("R9 sync blank", 64'(sync_out), 64'd0);
        pulse_cl();
        check("R9 still blank", 64'(com_lvl), 64'(0));
        power_save = 1'b0;
        @(negedge clk);
        eline = 0; efr = 1'b0;
        check("R9 restart line 0", 64'(com_lvl), 64'(exp_com(0, 0, 1)));
        check("R9 restart fr", 64'(fr_out), 64'd0);
        pulse_cl(); pulse_cl();
        // R12 mode change
        @(negedge clk) is_master = 1'b0;
        @(negedge clk);
        check("R12 blank on mode change", 64'(com_lvl), 64'(0));
        check("R11 slave fr/sync/oe", {61'd0, timing_oe, fr_out, sync_out}, 64'd0);
        // R10 slave
        pulse_cl();
        check("R10 slave waits", 64'(com_lvl), 64'(0));
        fr_in = 1'b1; sync_in = 1'b1;
        pulse_cl();
        sync_in = 1'b0;
        check("R10 slave locks line 1", 64'(com_lvl), 64'(exp_com(1, 1, 1)));
        fr_in = 1'b0;
        #1 check("R10 slave follows fr_in", 64'(com_lvl), 64'(exp_com(1, 0, 1)));
        for (int k = 0; k < 4; k++) pulse_cl();
        check("R10 slave wrap", 64'(com_lvl), 64'(exp_com(0, 0, 1)));
        for (int k = 0; k < 3; k++) pulse_cl();
        check("R10 slave line 3", 64'(com_lvl), 64'(exp_com(3, 0, 1)));
        sync_in = 1'b1;
        pulse_cl();
        sync_in = 1'b0;
        check("R10 slave resync", 64'(com_lvl), 64'(exp_com(1, 0, 1)));
        // R12 back to master
        @(negedge clk) is_master = 1'b1;
        @(negedge clk);
        check("R12 blank to master", 64'(com_lvl), 64'(0));
        @(negedge clk);
        check("R12 master restart", 64'(com_lvl), 64'(exp_com(0, 0, 1)));
        check("R11 master oe", 64'(timing_oe), 64'd1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule